// File: doc/BRIEF.md
# Color-Array Channel Rotation Sequencer

This block is the per-line control core of a column driver that feeds three color inputs (C1, C2, C3) to its output columns. For every group of three adjacent columns it drives a 2-bit channel select per column position, chosen from the panel's pixel layout, the line count and the shift direction. It also steers two ping-pong sample/hold banks, one sampling while the other drives the panel, and it gates the analog outputs.

A line strobe (INH) marks each horizontal line. The strobe is brought into the system clock domain by two flops and its high time is counted in clocks. A strobe that stays high for fewer than `MIN_INH_CLKS` clocks is discarded. A valid strobe acts on its falling edge: it moves the line rotation forward and swaps the roles of the two banks. After reset the channel selects are parked at an "off" code until the first valid strobe arms the sequencer. The column shift register, the analog sampling, the output buffers and the pad timing sit outside this block.

Top module: `color_rotation_seq`

## Requirements
- R1: `array_mode` uses `{th_bit, half_bit}` decoding: 2'b00 is vertical stripe, 2'b01 is single-side delta, 2'b11 is double-side delta, 2'b10 is mosaic. In stripe mode the routing never changes from line to line. The channel code is 0 for C1, 1 for C2, 2 for C3 and 3 for off. Column position p (0..2) is carried in `chan_sel[2p+1:2p]`.
- R2: Single-side delta alternates between two lines. With `dir_right`=1, positions 0,1,2 take (C1,C2,C3) and then (C2,C3,C1). With `dir_right`=0, positions are counted from the last column and take (C3,C2,C1) and then (C1,C3,C2).
- R3: Double-side delta alternates between two lines. Right: (C2,C3,C1) and then (C1,C2,C3). Left: (C3,C2,C1) and then (C1,C3,C2).
- R4: Mosaic follows a three-line cycle. Right: (C1,C2,C3), (C3,C1,C2), (C2,C3,C1). Left: (C3,C2,C1), (C2,C1,C3), (C1,C3,C2). In stripe mode the pattern is (C1,C2,C3) for right and (C3,C2,C1) for left.
- R5: While `rst` is high and afterwards, until the first valid strobe: `mux_enable`=0, every position of `chan_sel` is 3 (off), `sample_bank_sel`=0, `hold_bank_sel`=1 and `out_enable`=0.
- R6: The first valid strobe after reset raises `mux_enable` and selects the first line of the current mode's pattern. Each later valid strobe moves to the next line of the pattern.
- R7: A strobe whose synchronized high time is shorter than `MIN_INH_CLKS` (default 5) clocks changes neither `chan_sel`, nor the bank selects, nor `mux_enable`.
- R8: Each valid strobe inverts `sample_bank_sel`. `hold_bank_sel` is always its complement.
- R9: `out_enable` is high only while `mux_enable` is high and the synchronized strobe is low. It is low while the strobe is high.
- R10: The outputs update on the third rising clock edge after `inh_in` falls. Before that edge they keep their previous values.
- R11: Asserting `rst` in mid-operation returns all outputs to the R5 state. A fresh valid strobe is then needed, and it restarts at the first line of the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset |
| inh_in | input | 1 | Line strobe, asynchronous to `clk` |
| array_mode | input | 2 | Pixel layout select `{th_bit, half_bit}` |
| dir_right | input | 1 | 1 = right shift, 0 = left shift |
| chan_sel | output | 6 | Channel code for each of the three column positions |
| sample_bank_sel | output | 1 | Bank that is currently sampling |
| hold_bank_sel | output | 1 | Bank that is currently driving the outputs |
| out_enable | output | 1 | Connects the held bank to the outputs |
| mux_enable | output | 1 | High once the sequencer has been armed |

## Verification
The assertions assume that `array_mode` and `dir_right` stay steady across a strobe's falling edge. They also assume that `inh_in` is a clean level held for whole clock periods, so that the synchronized copy carries no glitches. The bench changes `inh_in`, the mode and the direction only at falling clock edges. It holds each strobe for a whole number of periods and lets several clocks pass after every falling edge before it compares the outputs.

// File: rtl/crs_pkg.sv
package crs_pkg;

  typedef enum logic [1:0] {
    ARR_STRIPE   = 2'b00,
    ARR_DELTA_1S = 2'b01,
    ARR_MOSAIC   = 2'b10,
    ARR_DELTA_2S = 2'b11
  } arr_mode_e;

  localparam int unsigned NUM_POS = 3;
  localparam int unsigned CH_W    = 2;
  localparam int unsigned SEL_W   = NUM_POS * CH_W;
  localparam logic [CH_W-1:0] CH_C1  = 2'd0;
  localparam logic [CH_W-1:0] CH_C2  = 2'd1;
  localparam logic [CH_W-1:0] CH_C3  = 2'd2;
  localparam logic [CH_W-1:0] CH_OFF = 2'd3;

  // number of distinct lines before the routing repeats
  function automatic logic [1:0] phase_period(arr_mode_e m);
    case (m)
      ARR_STRIPE:   return 2'd1;
      ARR_MOSAIC:   return 2'd3;
      default:      return 2'd2;
    endcase
  endfunction

  function automatic logic [1:0] next_phase(logic [1:0] p, arr_mode_e m);
    logic [2:0] nxt;
    nxt = {1'b0, p} + 3'd1;
    if (nxt >= {1'b0, phase_period(m)}) return 2'd0;
    return nxt[1:0];
  endfunction

  // pack three position codes, position 0 in the low bits
  function automatic logic [SEL_W-1:0] pack3(logic [CH_W-1:0] a,
                                             logic [CH_W-1:0] b,
                                             logic [CH_W-1:0] c);
    return {c, b, a};
  endfunction

  function automatic logic [SEL_W-1:0] route_pattern(arr_mode_e m, logic right,
                                                     logic [1:0] ph);
    logic [SEL_W-1:0] r;
    r = pack3(CH_C1, CH_C2, CH_C3);
    case (m)
      ARR_STRIPE:
        r = right ? pack3(CH_C1, CH_C2, CH_C3) : pack3(CH_C3, CH_C2, CH_C1);
      ARR_DELTA_1S:
        if (right) r = ph[0] ? pack3(CH_C2, CH_C3, CH_C1) : pack3(CH_C1, CH_C2, CH_C3);
        else       r = ph[0] ? pack3(CH_C1, CH_C3, CH_C2) : pack3(CH_C3, CH_C2, CH_C1);
      ARR_DELTA_2S:
        if (right) r = ph[0] ? pack3(CH_C1, CH_C2, CH_C3) : pack3(CH_C2, CH_C3, CH_C1);
        else       r = ph[0] ? pack3(CH_C1, CH_C3, CH_C2) : pack3(CH_C3, CH_C2, CH_C1);
      ARR_MOSAIC:
        if (right) begin
          case (ph)
            2'd1:    r = pack3(CH_C3, CH_C1, CH_C2);
            2'd2:    r = pack3(CH_C2, CH_C3, CH_C1);
            default: r = pack3(CH_C1, CH_C2, CH_C3);
          endcase
        end else begin
          case (ph)
            2'd1:    r = pack3(CH_C2, CH_C1, CH_C3);
            2'd2:    r = pack3(CH_C1, CH_C3, CH_C2);
            default: r = pack3(CH_C3, CH_C2, CH_C1);
          endcase
        end
      default: r = pack3(CH_C1, CH_C2, CH_C3);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/crs_inh_qualifier.sv
module crs_inh_qualifier #(
  parameter int unsigned MIN_INH_CLKS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic inh_in,
  output logic inh_sync,
  output logic line_adv
);
  localparam int unsigned CNT_W = $clog2(MIN_INH_CLKS + 1);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(MIN_INH_CLKS);

  logic meta_q, sync_q, sync_d_q;
  logic [CNT_W-1:0] run_q;
  logic fall_edge, width_ok;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      meta_q   <= 1'b0;
      sync_q   <= 1'b0;
      sync_d_q <= 1'b0;
      run_q    <= '0;
    end else begin
      meta_q   <= inh_in;
      sync_q   <= meta_q;
      sync_d_q <= sync_q;
      if (sync_q) begin
        if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
      end else begin
        run_q <= '0;
      end
    end
  end

  assign fall_edge = sync_d_q & ~sync_q;
  assign width_ok  = (run_q >= RUN_MAX);
  assign line_adv  = fall_edge & width_ok;
  assign inh_sync  = sync_q;

  // R10
  adv_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    line_adv |-> (!sync_q && $past(sync_q)));

endmodule

// File: rtl/crs_line_phase.sv
module crs_line_phase
  import crs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       line_adv,
  input  arr_mode_e  mode,
  output logic       armed,
  output logic [1:0] phase
);
  logic       armed_q;
  logic [1:0] phase_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      armed_q <= 1'b0;
      phase_q <= 2'd0;
    end else if (line_adv) begin
      if (!armed_q) armed_q <= 1'b1;
      else          phase_q <= next_phase(phase_q, mode);
    end
  end

  assign armed = armed_q;
  assign phase = phase_q;

  // R6
  arm_on_adv_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_q) |-> $past(line_adv));

  // R6
  first_line_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_q) |-> (phase_q == 2'd0));

  // R4
  mosaic_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (line_adv && armed_q && mode == ARR_MOSAIC) |=> (phase_q != $past(phase_q)));

endmodule

// File: rtl/crs_route_mux.sv
module crs_route_mux
  import crs_pkg::*;
(
  input  arr_mode_e         mode,
  input  logic              dir_right,
  input  logic [1:0]        phase,
  input  logic              enable,
  output logic [SEL_W-1:0]  chan_sel
);
  logic [SEL_W-1:0] pattern;

  assign pattern = route_pattern(mode, dir_right, phase);

  for (genvar p = 0; p < NUM_POS; p++) begin : g_pos
    assign chan_sel[p*CH_W +: CH_W] = enable ? pattern[p*CH_W +: CH_W] : CH_OFF;
  end

endmodule

// File: rtl/color_rotation_seq.sv
module color_rotation_seq #(
  parameter int unsigned MIN_INH_CLKS = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inh_in,
  input  logic [1:0] array_mode,
  input  logic       dir_right,
  output logic [5:0] chan_sel,
  output logic       sample_bank_sel,
  output logic       hold_bank_sel,
  output logic       out_enable,
  output logic       mux_enable
);
  import crs_pkg::*;

  localparam int unsigned CHK_W = $clog2(MIN_INH_CLKS + 1);
  localparam logic [CHK_W-1:0] CHK_MAX = CHK_W'(MIN_INH_CLKS);

  logic       inh_sync, line_adv, armed;
  logic [1:0] phase;
  logic       sample_q;
  arr_mode_e  mode;

  assign mode = arr_mode_e'(array_mode);

  crs_inh_qualifier #(.MIN_INH_CLKS(MIN_INH_CLKS)) u_qual (
    .clk      (clk),
    .rst      (rst),
    .inh_in   (inh_in),
    .inh_sync (inh_sync),
    .line_adv (line_adv)
  );

  crs_line_phase u_phase (
    .clk      (clk),
    .rst      (rst),
    .line_adv (line_adv),
    .mode     (mode),
    .armed    (armed),
    .phase    (phase)
  );

  crs_route_mux u_mux (
    .mode      (mode),
    .dir_right (dir_right),
    .phase     (phase),
    .enable    (armed),
    .chan_sel  (chan_sel)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst)           sample_q <= 1'b0;
    else if (line_adv) sample_q <= ~sample_q;
  end

  assign sample_bank_sel = sample_q;
  assign hold_bank_sel   = ~sample_q;
  assign mux_enable      = armed;
  assign out_enable      = armed & ~inh_sync;

  // checker-side count of synchronized strobe high time
  logic [CHK_W-1:0] chk_run_q;
  always_ff @(posedge clk or posedge rst) begin
    if (rst) chk_run_q <= '0;
    else if (!inh_sync) chk_run_q <= '0;
    else if (chk_run_q != CHK_MAX) chk_run_q <= chk_run_q + 1'b1;
  end

  // R7
  short_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    line_adv |-> (chk_run_q == CHK_MAX));

  // R8
  bank_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    line_adv |=> (sample_bank_sel != $past(sample_bank_sel)));

  // R8
  bank_steady_chk: assert property (@(posedge clk) disable iff (rst)
    !line_adv |=> $stable(sample_bank_sel));

  // R9
  out_gate_chk: assert property (@(posedge clk) disable iff (rst)
    out_enable |-> (mux_enable && !inh_sync));

  // R5
  parked_chk: assert property (@(posedge clk) disable iff (rst)
    !mux_enable |-> (chan_sel == {3{CH_OFF}}));

  // R1
  stripe_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (mux_enable && $past(mux_enable) && mode == ARR_STRIPE && $stable(array_mode)
     && $stable(dir_right)) |-> $stable(chan_sel));

endmodule

// File: tb/color_rotation_seq_tb.sv
module color_rotation_seq_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       inh_in;
  logic [1:0] array_mode;
  logic       dir_right;
  logic [5:0] chan_sel;
  logic       sample_bank_sel, hold_bank_sel, out_enable, mux_enable;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  color_rotation_seq u_dut (
    .clk(clk), .rst(rst), .inh_in(inh_in), .array_mode(array_mode),
    .dir_right(dir_right), .chan_sel(chan_sel), .sample_bank_sel(sample_bank_sel),
    .hold_bank_sel(hold_bank_sel), .out_enable(out_enable), .mux_enable(mux_enable)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // rotation form of the routing: right -> (p + r) mod 3, left -> (r - p) mod 3
  function automatic int rot_of(int mode, bit right, int ph);
    if (right) begin
      case (mode)
        0: return 0;
        1: return (ph == 0) ? 0 : 1;
        3: return (ph == 0) ? 1 : 0;
        default: return (ph == 0) ? 0 : ((ph == 1) ? 2 : 1);
      endcase
    end else begin
      case (mode)
        0: return 2;
        1, 3: return (ph == 0) ? 2 : 0;
        default: return 2 - ph;
      endcase
    end
  endfunction

  function automatic int exp_sel(int mode, bit right, int ph);
    int r, v;
    v = 0;
    r = rot_of(mode, right, ph);
    for (int p = 0; p < 3; p++) begin
      int c;
      c = right ? (p + r) % 3 : (r - p + 3) % 3;
      v = v | (c << (2 * p));
    end
    return v;
  endfunction

  function automatic int period_of(int mode);
    return (mode == 0) ? 1 : ((mode == 2) ? 3 : 2);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; inh_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    inh_in = 1'b1;
    repeat (n) @(negedge clk);
    inh_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic check_both_dirs(input int mode, input int ph, input string tag);
    dir_right = 1'b1; #1;
    chk(chan_sel, exp_sel(mode, 1'b1, ph), {tag, " right"});
    dir_right = 1'b0; #1;
    chk(chan_sel, exp_sel(mode, 1'b0, ph), {tag, " left"});
    dir_right = 1'b1; #1;
  endtask

  task automatic t_reset_state();
    rst = 1'b1; inh_in = 1'b0; array_mode = 2'b00; dir_right = 1'b1;
    repeat (3) @(negedge clk);
    chk(mux_enable, 0, "R5 mux_enable in reset");
    chk(chan_sel, 6'h3F, "R5 chan_sel off in reset");
    chk(sample_bank_sel, 0, "R5 sample bank in reset");
    chk(hold_bank_sel, 1, "R5 hold bank in reset");
    chk(out_enable, 0, "R5 out_enable in reset");
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(chan_sel, 6'h3F, "R5 chan_sel off before first strobe");
    chk(out_enable, 0, "R5 out_enable low before first strobe");
  endtask

  task automatic t_mode(input int mode, input int nlines, input string tag);
    do_reset();
    array_mode = mode[1:0];
    dir_right = 1'b1;
    pulse(5);
    chk(mux_enable, 1, "R6 armed by first strobe");
    for (int l = 0; l < nlines; l++) begin
      check_both_dirs(mode, l % period_of(mode), tag);
      pulse(6);
    end
  endtask

  task automatic t_short_pulse();
    int sel0, bank0;
    do_reset();
    array_mode = 2'b10;
    pulse(4);
    chk(mux_enable, 0, "R7 short strobe does not arm");
    chk(sample_bank_sel, 0, "R7 short strobe keeps bank before arm");
    pulse(5);
    sel0 = chan_sel; bank0 = sample_bank_sel;
    pulse(4);
    chk(chan_sel, sel0, "R7 short strobe keeps routing");
    chk(sample_bank_sel, bank0, "R7 short strobe keeps bank");
    pulse(5);
    chk(chan_sel, exp_sel(2, 1'b1, 1), "R6 next valid strobe advances");
  endtask

  task automatic t_banks();
    do_reset();
    array_mode = 2'b01;
    for (int k = 1; k <= 4; k++) begin
      pulse(5);
      chk(sample_bank_sel, k % 2, "R8 sample bank alternates");
      chk(hold_bank_sel, (k + 1) % 2, "R8 hold bank is complement");
    end
  endtask

  task automatic t_out_enable();
    do_reset();
    array_mode = 2'b00;
    pulse(5);
    chk(out_enable, 1, "R9 enabled with strobe low");
    @(negedge clk);
    inh_in = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_enable, 0, "R9 disabled while strobe high");
    repeat (3) @(negedge clk);
    inh_in = 1'b0;
    repeat (4) @(negedge clk);
    chk(out_enable, 1, "R9 re-enabled after strobe");
  endtask

  task automatic t_latency();
    do_reset();
    array_mode = 2'b00;
    @(negedge clk);
    inh_in = 1'b1;
    repeat (6) @(negedge clk);
    inh_in = 1'b0;
    repeat (2) @(negedge clk);
    chk(mux_enable, 0, "R10 no change after two edges");
    @(negedge clk);
    chk(mux_enable, 1, "R10 change at third edge");
    chk(sample_bank_sel, 1, "R10 bank swaps at third edge");
  endtask

  task automatic t_mid_reset();
    do_reset();
    array_mode = 2'b10;
    pulse(5); pulse(5); pulse(5);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mux_enable, 0, "R11 reset disarms");
    chk(chan_sel, 6'h3F, "R11 reset parks selects");
    chk(sample_bank_sel, 0, "R11 reset clears bank");
    pulse(5);
    chk(chan_sel, exp_sel(2, 1'b1, 0), "R11 restart at first line");
  endtask

  initial begin
    rst = 1'b1; inh_in = 1'b0; array_mode = 2'b00; dir_right = 1'b1;
    t_reset_state();
    t_mode(0, 3, "R1 stripe");
    t_mode(1, 4, "R2 single delta");
    t_mode(3, 4, "R3 double delta");
    t_mode(2, 6, "R4 mosaic");
    t_short_pulse();
    t_banks();
    t_out_enable();
    t_latency();
    t_mid_reset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule